// File: doc/BRIEF.md
# Iterative Shift and Rotate Unit

This block executes the immediate-count shift and rotate group of a 16-bit processor core. The core hands it an 8-bit or 16-bit operand, a 3-bit operation code, an 8-bit repeat count, the current status flags and a marker telling whether the operand was fetched from memory or taken from a register. After a fixed setup delay, the unit applies one single-bit step per clock and decrements the count each time. When the count is exhausted, it pulses `done_o` for one cycle with the final value and flags on its outputs.

The setup delay is longer for memory operands than for register operands. The unit does not mask or reduce the count, so a count larger than the width keeps stepping. Besides the seven usual operations, it supports an extra code that fills the operand with ones. Parity, zero and sign are touched only by the shift-type codes. Instruction fetch, operand addressing and writeback stay with the surrounding core.

Top module: `srot_iter_unit`

## Requirements
- R1: A start request with `busy_o` low is accepted on that clock edge, and `busy_o` is high from the next cycle until the result is delivered. A start request while `busy_o` is high is ignored and does not change the delivered result or its timing.
- R2: Let D be 9 for a memory operand (`mem_i`=1) or 6 for a register operand, and let N be the count. `done_o` rises D+N+1 cycles after the accepting edge and stays high for exactly one cycle.
- R3: With N=0 the result equals the operand (masked to the width) and `flags_o` equals `flags_i`. The bit layout of `flags_i` and `flags_o` is: bit0 CF, bit1 OF, bit2 AF, bit3 PF, bit4 ZF, bit5 SF.
- R4: Code 000 rotates left: CF takes the top bit and the top bit re-enters at bit 0. Code 001 rotates right: CF takes bit 0 and bit 0 re-enters at the top bit.
- R5: Code 010 rotates left through carry: the old CF enters bit 0 and the new CF is the bit shifted out of the top. Code 011 rotates right through carry: the old CF enters the top bit and the new CF is the bit shifted out of bit 0.
- R6: Code 100 shifts left with zero fill and sets CF from the top bit. Code 101 shifts right with zero fill and sets CF from bit 0. Code 111 shifts right, keeps the previous top bit in the top position and sets CF from bit 0.
- R7: Code 110 with N>0 sets the value to all ones within the active width and clears CF.
- R8: After each step, AF is the new bit 4 for code 100 and 0 for every other code.
- R9: After each step, OF is the XOR of the two most significant bits of the new value within the active width.
- R10: For codes 100, 101, 110 and 111, each step sets PF to the even parity of the low 8 bits, ZF when the value is zero and SF to the top bit. Rotate codes 000 to 011 leave PF, ZF and SF unchanged.
- R11: `wide_i`=0 selects 8 bits (the top bit is bit 7) and `wide_i`=1 selects 16 bits (the top bit is bit 15). In 8-bit mode, `result_o[15:8]` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request |
| mem_i | input | 1 | 1 = operand came from memory (longer setup delay) |
| wide_i | input | 1 | 0 = 8-bit operand, 1 = 16-bit operand |
| op_i | input | 3 | Operation code |
| count_i | input | 8 | Number of single-bit steps |
| operand_i | input | 16 | Operand value |
| flags_i | input | 6 | Incoming flags {SF,ZF,PF,AF,OF,CF} |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 16 | Result value, valid while done_o is high |
| flags_o | output | 6 | Result flags, same layout as flags_i |

## Verification
The bench builds the unit with its default setup delays of 9 and 6 cycles and an 8-bit count. These values let it check the exact arrival cycle for both operand sources and for counts of 0, 1, 20 and the maximum of 255. The full count range also exercises counts larger than the operand width, where left shifts drain the value to zero and the rotate codes wrap around repeatedly.

// File: rtl/srot_pkg.sv
package srot_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 8;
    localparam int FLAG_W = 6;

    typedef enum logic [2:0] {
        OP_ROL  = 3'b000,
        OP_ROR  = 3'b001,
        OP_RCL  = 3'b010,
        OP_RCR  = 3'b011,
        OP_SHL  = 3'b100,
        OP_SHR  = 3'b101,
        OP_ONES = 3'b110,
        OP_SAR  = 3'b111
    } shop_e;

    typedef struct packed {
        logic sf;
        logic zf;
        logic pf;
        logic af;
        logic of;
        logic cf;
    } flags_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STEP
    } seq_state_e;

    function automatic logic [WORD_W-1:0] width_mask(input logic wide);
        return wide ? {WORD_W{1'b1}} : {{(WORD_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
    endfunction

    function automatic logic [WORD_W-1:0] top_onehot(input logic wide);
        logic [WORD_W-1:0] v;
        v = '0;
        if (wide) v[WORD_W-1] = 1'b1;
        else      v[BYTE_W-1] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/srot_flag_eval.sv
module srot_flag_eval
    import srot_pkg::*;
(
    input  logic [WORD_W-1:0] value,
    input  logic              wide,
    output logic              par_even,
    output logic              is_zero,
    output logic              sign,
    output logic              ovf
);
    always_comb begin
        par_even = ~^value[BYTE_W-1:0];
        is_zero  = ((value & width_mask(wide)) == '0);
        sign     = wide ? value[WORD_W-1] : value[BYTE_W-1];
        ovf      = wide ? (value[WORD_W-1] ^ value[WORD_W-2])
                        : (value[BYTE_W-1] ^ value[BYTE_W-2]);
    end
endmodule

// File: rtl/srot_step.sv
module srot_step
    import srot_pkg::*;
(
    input  shop_e             op,
    input  logic              wide,
    input  logic [WORD_W-1:0] cur_val,
    input  flags_t            cur_flags,
    output logic [WORD_W-1:0] nxt_val,
    output flags_t            nxt_flags
);
    logic [WORD_W-1:0] msk;
    logic [WORD_W-1:0] topv;
    logic [WORD_W-1:0] left1;
    logic [WORD_W-1:0] right1;
    logic              msb;
    logic              carry_out;
    logic              e_par;
    logic              e_zero;
    logic              e_sign;
    logic              e_ovf;

    always_comb begin
        msk    = width_mask(wide);
        topv   = top_onehot(wide);
        msb    = |(cur_val & topv);
        left1  = (cur_val << 1) & msk;
        right1 = (cur_val & msk) >> 1;
        case (op)
            OP_ROL: begin
                carry_out = msb;
                nxt_val   = left1 | {{(WORD_W-1){1'b0}}, msb};
            end
            OP_ROR: begin
                carry_out = cur_val[0];
                nxt_val   = right1 | (cur_val[0] ? topv : '0);
            end
            OP_RCL: begin
                carry_out = msb;
                nxt_val   = left1 | {{(WORD_W-1){1'b0}}, cur_flags.cf};
            end
            OP_RCR: begin
                carry_out = cur_val[0];
                nxt_val   = right1 | (cur_flags.cf ? topv : '0);
            end
            OP_SHL: begin
                carry_out = msb;
                nxt_val   = left1;
            end
            OP_SHR: begin
                carry_out = cur_val[0];
                nxt_val   = right1;
            end
            OP_ONES: begin
                carry_out = 1'b0;
                nxt_val   = msk;
            end
            default: begin
                carry_out = cur_val[0];
                nxt_val   = right1 | (msb ? topv : '0);
            end
        endcase
    end

    srot_flag_eval u_eval (
        .value    (nxt_val),
        .wide     (wide),
        .par_even (e_par),
        .is_zero  (e_zero),
        .sign     (e_sign),
        .ovf      (e_ovf)
    );

    always_comb begin
        nxt_flags    = cur_flags;
        nxt_flags.cf = carry_out;
        nxt_flags.of = e_ovf;
        nxt_flags.af = (op == OP_SHL) ? nxt_val[4] : 1'b0;
        if (op[2]) begin
            nxt_flags.pf = e_par;
            nxt_flags.zf = e_zero;
            nxt_flags.sf = e_sign;
        end
    end
endmodule

// File: rtl/srot_sequencer.sv
module srot_sequencer
    import srot_pkg::*;
#(
    parameter int SETUP_MEM = 9,
    parameter int SETUP_REG = 6,
    parameter int CNT_BITS  = CNT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                mem,
    input  logic [CNT_BITS-1:0] count,
    output logic                busy,
    output logic                done,
    output logic                load,
    output logic                step_en
);
    localparam int SU_MAX = (SETUP_MEM > SETUP_REG) ? SETUP_MEM : SETUP_REG;
    localparam int SU_W   = $clog2(SU_MAX + 1);

    seq_state_e          state;
    logic [SU_W-1:0]     setup_left;
    logic [CNT_BITS-1:0] steps_left;

    assign busy    = (state != ST_IDLE);
    assign load    = (state == ST_IDLE) && start;
    assign step_en = (state == ST_STEP) && (steps_left != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            setup_left <= '0;
            steps_left <= '0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        setup_left <= mem ? SU_W'(SETUP_MEM) : SU_W'(SETUP_REG);
                        steps_left <= count;
                        state      <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    setup_left <= setup_left - 1'b1;
                    if (setup_left <= SU_W'(1)) state <= ST_STEP;
                end
                default: begin
                    if (steps_left == '0) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        steps_left <= steps_left - 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/srot_iter_unit.sv
module srot_iter_unit
    import srot_pkg::*;
#(
    parameter int SETUP_MEM = 9,
    parameter int SETUP_REG = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              mem_i,
    input  logic              wide_i,
    input  logic [2:0]        op_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [WORD_W-1:0] operand_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [WORD_W-1:0] result_o,
    output logic [FLAG_W-1:0] flags_o
);
    logic              load;
    logic              step_en;
    shop_e             op_q;
    logic              wide_q;
    logic [WORD_W-1:0] val_q;
    flags_t            flg_q;
    logic [WORD_W-1:0] val_d;
    flags_t            flg_d;

    srot_sequencer #(
        .SETUP_MEM (SETUP_MEM),
        .SETUP_REG (SETUP_REG),
        .CNT_BITS  (CNT_W)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start_i),
        .mem     (mem_i),
        .count   (count_i),
        .busy    (busy_o),
        .done    (done_o),
        .load    (load),
        .step_en (step_en)
    );

    srot_step u_step (
        .op        (op_q),
        .wide      (wide_q),
        .cur_val   (val_q),
        .cur_flags (flg_q),
        .nxt_val   (val_d),
        .nxt_flags (flg_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= OP_ROL;
            wide_q <= 1'b0;
            val_q  <= '0;
            flg_q  <= '0;
        end else if (load) begin
            op_q   <= shop_e'(op_i);
            wide_q <= wide_i;
            val_q  <= operand_i & width_mask(wide_i);
            flg_q  <= flags_t'(flags_i);
        end else if (step_en) begin
            val_q  <= val_d;
            flg_q  <= flg_d;
        end
    end

    assign result_o = val_q;
    assign flags_o  = flg_q;
endmodule

// File: rtl/srot_iter_chk.sv
module srot_iter_chk
    import srot_pkg::*;
#(
    parameter int SETUP_MEM = 9,
    parameter int SETUP_REG = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              mem_i,
    input  logic              wide_i,
    input  logic [2:0]        op_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [WORD_W-1:0] operand_i,
    input  logic [FLAG_W-1:0] flags_i,
    input  logic              busy_o,
    input  logic              done_o,
    input  logic [WORD_W-1:0] result_o,
    input  logic [FLAG_W-1:0] flags_o
);
    logic [2:0]        c_op;
    logic              c_wide;
    logic [CNT_W-1:0]  c_cnt;
    logic [WORD_W-1:0] c_val;
    logic [FLAG_W-1:0] c_flg;
    logic [15:0]       c_lat;
    logic [15:0]       elapsed;

    always_ff @(posedge clk) begin
        if (rst) begin
            c_op    <= '0;
            c_wide  <= 1'b0;
            c_cnt   <= '0;
            c_val   <= '0;
            c_flg   <= '0;
            c_lat   <= '0;
            elapsed <= '0;
        end else if (start_i && !busy_o) begin
            c_op    <= op_i;
            c_wide  <= wide_i;
            c_cnt   <= count_i;
            c_val   <= operand_i & width_mask(wide_i);
            c_flg   <= flags_i;
            c_lat   <= 16'(mem_i ? SETUP_MEM : SETUP_REG) + 16'(count_i) + 16'd1;
            elapsed <= '0;
        end else if (elapsed != 16'hFFFF) begin
            elapsed <= elapsed + 16'd1;
        end
    end

    // R1
    busy_after_start_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    // R2
    done_latency_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (elapsed == c_lat));

    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R3
    zero_count_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && c_cnt == '0) |-> (result_o == c_val && flags_o == c_flg));

    // R7
    fill_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && c_op == 3'b110 && c_cnt != '0) |->
            (result_o == width_mask(c_wide) && !flags_o[0]));

    // R8
    aux_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && c_op != 3'b100 && c_cnt != '0) |-> !flags_o[2]);

    // R11
    narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !c_wide) |-> (result_o[15:8] == 8'h00));
endmodule

bind srot_iter_unit srot_iter_chk #(
    .SETUP_MEM (SETUP_MEM),
    .SETUP_REG (SETUP_REG)
) u_chk (.*);

// File: tb/test_srot_iter_unit.sv
module test_srot_iter_unit;
    localparam int CLK_PERIOD = 10;
    localparam int D_MEM = 9;
    localparam int D_REG = 6;
    localparam int WATCHDOG = 100000;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic        mem_i;
    logic        wide_i;
    logic [2:0]  op_i;
    logic [7:0]  count_i;
    logic [15:0] operand_i;
    logic [5:0]  flags_i;
    logic        busy_o;
    logic        done_o;
    logic [15:0] result_o;
    logic [5:0]  flags_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 0;

    typedef struct {
        logic [15:0] res;
        logic [5:0]  flg;
        int          when;
        string       tag;
    } exp_t;

    exp_t sb[$];

    srot_iter_unit #(.SETUP_MEM(D_MEM), .SETUP_REG(D_REG)) i_srot_iter_unit (
        .clk(clk), .rst(rst), .start_i(start_i), .mem_i(mem_i), .wide_i(wide_i),
        .op_i(op_i), .count_i(count_i), .operand_i(operand_i), .flags_i(flags_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .flags_o(flags_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Reference model written from the requirements: {flags, value}
    function automatic logic [21:0] model(input logic [2:0] op, input logic wide,
                                          input logic [15:0] v, input int n,
                                          input logic [5:0] f);
        logic [15:0] m;
        logic [15:0] d;
        logic [15:0] prev;
        logic [5:0]  fl;
        int          t;
        m  = wide ? 16'hFFFF : 16'h00FF;
        t  = wide ? 15 : 7;
        d  = v & m;
        fl = f;
        for (int i = 0; i < n; i++) begin
            prev = d;
            case (op)
                3'd0: begin fl[0] = prev[t]; d = ((prev << 1) & m) | 16'(prev[t]); end
                3'd1: begin fl[0] = prev[0]; d = prev >> 1; d[t] = prev[0]; end
                3'd2: begin d = ((prev << 1) & m) | 16'(fl[0]); fl[0] = prev[t]; end
                3'd3: begin d = prev >> 1; d[t] = fl[0]; fl[0] = prev[0]; end
                3'd4: begin fl[0] = prev[t]; d = (prev << 1) & m; end
                3'd5: begin fl[0] = prev[0]; d = prev >> 1; end
                3'd6: begin fl[0] = 1'b0; d = m; end
                default: begin fl[0] = prev[0]; d = prev >> 1; d[t] = prev[t]; end
            endcase
            fl[1] = d[t] ^ d[t-1];
            fl[2] = (op == 3'd4) ? d[4] : 1'b0;
            if (op >= 3'd4) begin
                fl[3] = ~^d[7:0];
                fl[4] = (d == 16'h0);
                fl[5] = d[t];
            end
        end
        return {fl, d};
    endfunction

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic push_exp(input logic mem, input logic wide, input logic [2:0] op,
                            input int n, input logic [15:0] v, input logic [5:0] f,
                            input string tag);
        exp_t e;
        logic [21:0] r;
        r      = model(op, wide, v, n, f);
        e.res  = r[15:0];
        e.flg  = r[21:16];
        e.when = cyc + (mem ? D_MEM : D_REG) + n + 2;
        e.tag  = tag;
        sb.push_back(e);
    endtask

    task automatic drive(input logic mem, input logic wide, input logic [2:0] op,
                         input int n, input logic [15:0] v, input logic [5:0] f);
        start_i   = 1'b1;
        mem_i     = mem;
        wide_i    = wide;
        op_i      = op;
        count_i   = 8'(n);
        operand_i = v;
        flags_i   = f;
    endtask

    task automatic run(input logic mem, input logic wide, input logic [2:0] op,
                       input int n, input logic [15:0] v, input logic [5:0] f,
                       input string tag);
        @(negedge clk);
        drive(mem, wide, op, n, v, f);
        push_exp(mem, wide, op, n, v, f, tag);
        @(negedge clk);
        start_i = 1'b0;
        while (sb.size() != 0) @(negedge clk);
    endtask

    // Monitor: compare each done pulse with the head of the scoreboard
    always @(negedge clk) begin
        if (!rst && done_o) begin
            if (sb.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R1 unexpected done: actual 1 expected 0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, 32'(result_o), 32'(e.res), "result");
                check(e.tag, 32'(flags_o),  32'(e.flg), "flags");
                check("R2", 32'(cyc), 32'(e.when), "done cycle");
            end
        end
    end

    initial begin
        while (!finished && cyc < WATCHDOG) @(negedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, WATCHDOG);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        drive(1'b0, 1'b0, 3'd0, 0, 16'h0, 6'h0);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", 32'(busy_o), 32'd0, "busy after reset");
        check("R2", 32'(done_o), 32'd0, "done after reset");

        run(1'b0, 1'b0, 3'd0, 1,   16'h0081, 6'h00, "R4");  // ROL8
        run(1'b1, 1'b1, 3'd1, 3,   16'h0001, 6'h00, "R4");  // ROR16
        run(1'b0, 1'b0, 3'd2, 2,   16'h0080, 6'h01, "R5");  // RCL8, CF in
        run(1'b1, 1'b1, 3'd3, 1,   16'h0001, 6'h00, "R5");  // RCR16
        run(1'b0, 1'b1, 3'd3, 3,   16'h1234, 6'h01, "R5");
        run(1'b0, 1'b0, 3'd4, 1,   16'h0008, 6'h00, "R8");  // SHL AF from bit 4
        run(1'b0, 1'b1, 3'd5, 4,   16'h8001, 6'h3F, "R6");  // SHR16
        run(1'b1, 1'b0, 3'd7, 3,   16'h0080, 6'h00, "R6");  // SAR8 negative
        run(1'b0, 1'b1, 3'd7, 2,   16'h7FF0, 6'h00, "R6");  // SAR16 positive
        run(1'b0, 1'b1, 3'd6, 2,   16'h1200, 6'h01, "R7");  // fill ones
        run(1'b1, 1'b0, 3'd6, 1,   16'h0000, 6'h3F, "R7");
        run(1'b0, 1'b1, 3'd4, 0,   16'hBEEF, 6'h2A, "R3");  // zero count
        run(1'b1, 1'b0, 3'd1, 0,   16'h5A3C, 6'h15, "R3");
        run(1'b0, 1'b0, 3'd0, 1,   16'h0040, 6'h00, "R9");  // OF set
        run(1'b0, 1'b1, 3'd4, 1,   16'h4000, 6'h00, "R9");
        run(1'b0, 1'b0, 3'd4, 20,  16'h0001, 6'h00, "R10"); // drains to zero
        run(1'b0, 1'b0, 3'd1, 1,   16'h0003, 6'h38, "R10"); // rotate keeps PZS
        run(1'b0, 1'b0, 3'd5, 1,   16'hABCD, 6'h00, "R11"); // upper byte dropped
        run(1'b1, 1'b1, 3'd0, 255, 16'h8421, 6'h00, "R2");  // maximum count
        run(1'b0, 1'b0, 3'd2, 9,   16'h00A5, 6'h00, "R5");  // full carry loop

        // R1: requests while busy are ignored
        @(negedge clk);
        drive(1'b0, 1'b0, 3'd4, 2, 16'h0011, 6'h00);
        push_exp(1'b0, 1'b0, 3'd4, 2, 16'h0011, 6'h00, "R1");
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            drive(1'b1, 1'b1, 3'd6, 50, 16'hFFFF, 6'h3F);
        end
        @(negedge clk);
        start_i = 1'b0;
        while (sb.size() != 0) @(negedge clk);
        repeat (60) @(negedge clk);
        check("R1", 32'(busy_o), 32'd0, "idle after ignored requests");

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule